// File: doc/BRIEF.md
# Fixed-Priority Shared-Line Selector

This block lets four devices share one output line. Each device raises a request and offers a data word. In every cycle the block picks the requesting device with the best fixed rank and places that device's word on the shared line. It also raises an acceptance return to that device alone, so each device knows whether its word was the one carried.

When nobody requests, the line is not left floating. It carries all zeros, every acceptance is low, and a busy flag tells the consumer that the line holds nothing. A parameter chooses the output timing. With the default, the line, the acceptances and busy are all taken from one output register that is cleared by a synchronous active-high reset. With the other setting, the selection path feeds the ports with no register.

Top module: `prio_line_mux`

## Requirements
- R1: Rank is fixed by device index. Device 0 (bit 0 of `req`, device A) wins over device 1, device 1 wins over device 2, and device 2 wins over device 3 (device D).
- R2: `line_out` carries the word of the winning device. Device k's word sits in bits `[k*DATA_W +: DATA_W]` of `dev_data`.
- R3: `ack[k]` is high only when device k is requesting and its word is the one on `line_out`. At most one bit of `ack` is high at a time, and `ack[k]` stays low while any lower-index device requests.
- R4: With no request active, `line_out` is all zeros and `ack` is all zeros.
- R5: `busy` is high exactly when at least one request is active.
- R6: With `REG_OUT`=1, `line_out`, `ack` and `busy` reflect the inputs sampled at the previous rising clock edge. With `REG_OUT`=0, they follow the inputs in the same cycle.
- R7: With `REG_OUT`=1, a rising edge that samples `rst` high clears `line_out`, `ack` and `busy` to zero, whatever the requests are.
- R8: The words of devices that do not win have no effect on `line_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used only when the output register is present |
| rst | input | 1 | Synchronous active-high reset of the output register |
| req | input | NUM_DEV | Per-device request; bit 0 has the best rank |
| dev_data | input | NUM_DEV*DATA_W | Device words packed side by side, device 0 in the low bits |
| ack | output | NUM_DEV | Per-device acceptance, one-hot or zero |
| line_out | output | DATA_W | Shared output line |
| busy | output | 1 | High when any request is active |

## Verification
The bench builds two copies of the block side by side, both at the default four devices and eight-bit words. One copy has `REG_OUT`=1 and the other has `REG_OUT`=0. Both copies get the same request patterns, so the registered copy's one-cycle delay and its synchronous clear can be checked against the same-cycle result of the combinational copy. Holding a single winner while the losers' words and the winner's own word change shows which word the line follows.

// File: rtl/prio_mux_pkg.sv
package prio_mux_pkg;
  parameter int unsigned DEF_NUM_DEV = 4;
  parameter int unsigned DEF_DATA_W  = 8;
  parameter bit          DEF_REG_OUT = 1'b1;
endpackage

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int unsigned NUM_DEV = prio_mux_pkg::DEF_NUM_DEV
) (
  input  logic [NUM_DEV-1:0] req,
  output logic [NUM_DEV-1:0] grant,
  output logic               any_req
);
  // blocked[k] is high when some device with a lower index requests
  logic [NUM_DEV:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_rank
    assign grant[k]     = req[k] & ~blocked[k];
    assign blocked[k+1] = blocked[k] | req[k];
  end

  assign any_req = blocked[NUM_DEV];
endmodule

// File: rtl/prio_data_sel.sv
module prio_data_sel #(
  parameter int unsigned NUM_DEV = prio_mux_pkg::DEF_NUM_DEV,
  parameter int unsigned DATA_W  = prio_mux_pkg::DEF_DATA_W
) (
  input  logic [NUM_DEV-1:0]        grant,
  input  logic [NUM_DEV*DATA_W-1:0] data_flat,
  output logic [DATA_W-1:0]         sel_out
);
  // AND-OR tree: a zero grant vector gives an all-zero word
  logic [DATA_W-1:0] acc [NUM_DEV+1];
  assign acc[0] = '0;

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_gate
    assign acc[k+1] = acc[k] | ({DATA_W{grant[k]}} & data_flat[k*DATA_W +: DATA_W]);
  end

  assign sel_out = acc[NUM_DEV];
endmodule

// File: rtl/prio_out_stage.sv
module prio_out_stage #(
  parameter int unsigned WIDTH   = 1,
  parameter bit          REG_OUT = prio_mux_pkg::DEF_REG_OUT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end
  end else begin : g_comb
    logic unused_ctl;
    assign unused_ctl = clk ^ rst;
    assign q = d;
  end
endmodule

// File: rtl/prio_line_mux.sv
module prio_line_mux #(
  parameter int unsigned NUM_DEV = prio_mux_pkg::DEF_NUM_DEV,
  parameter int unsigned DATA_W  = prio_mux_pkg::DEF_DATA_W,
  parameter bit          REG_OUT = prio_mux_pkg::DEF_REG_OUT
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_DEV-1:0]        req,
  input  logic [NUM_DEV*DATA_W-1:0] dev_data,
  output logic [NUM_DEV-1:0]        ack,
  output logic [DATA_W-1:0]         line_out,
  output logic                      busy
);
  localparam int unsigned BUNDLE_W = DATA_W + NUM_DEV + 1;

  logic [NUM_DEV-1:0]  grant;
  logic                any_req;
  logic [DATA_W-1:0]   sel_word;
  logic [BUNDLE_W-1:0] bundle_d, bundle_q;

  prio_resolver #(.NUM_DEV(NUM_DEV)) u_res (
    .req     (req),
    .grant   (grant),
    .any_req (any_req)
  );

  prio_data_sel #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W)) u_sel (
    .grant     (grant),
    .data_flat (dev_data),
    .sel_out   (sel_word)
  );

  assign bundle_d = {any_req, grant, sel_word};

  prio_out_stage #(.WIDTH(BUNDLE_W), .REG_OUT(REG_OUT)) u_out (
    .clk (clk),
    .rst (rst),
    .d   (bundle_d),
    .q   (bundle_q)
  );

  assign line_out = bundle_q[DATA_W-1:0];
  assign ack      = bundle_q[DATA_W +: NUM_DEV];
  assign busy     = bundle_q[BUNDLE_W-1];
endmodule

// File: rtl/prio_line_mux_chk.sv
module prio_line_mux_chk #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned DATA_W  = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_DEV-1:0]        req,
  input logic [NUM_DEV*DATA_W-1:0] dev_data,
  input logic [NUM_DEV-1:0]        ack,
  input logic [DATA_W-1:0]         line_out,
  input logic                      busy
);
  // Inputs aligned to the cycle the outputs describe
  logic [NUM_DEV-1:0]        req_ref;
  logic [NUM_DEV*DATA_W-1:0] data_ref;
  logic                      live;

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk) begin
      req_ref  <= req;
      data_ref <= dev_data;
    end
  end else begin : g_now
    assign req_ref  = req;
    assign data_ref = dev_data;
  end

  assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    live |-> $onehot0(ack));

  assert_busy_R5: assert property (@(posedge clk) disable iff (rst)
    live |-> (busy == (req_ref != '0)));

  assert_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (live && req_ref == '0) |-> (ack == '0 && line_out == '0));

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
    localparam logic [NUM_DEV-1:0] LOWER = (NUM_DEV'(1) << k) - NUM_DEV'(1);

    assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
      (live && ack[k]) |-> req_ref[k]);

    assert_rank_R1: assert property (@(posedge clk) disable iff (rst)
      (live && ack[k]) |-> ((req_ref & LOWER) == '0));

    assert_winner_acked_R1: assert property (@(posedge clk) disable iff (rst)
      (live && req_ref[k] && (req_ref & LOWER) == '0) |-> ack[k]);

    assert_word_R2: assert property (@(posedge clk) disable iff (rst)
      (live && ack[k]) |-> (line_out == data_ref[k*DATA_W +: DATA_W]));
  end
endmodule

bind prio_line_mux prio_line_mux_chk #(
  .NUM_DEV(NUM_DEV), .DATA_W(DATA_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .dev_data (dev_data),
  .ack      (ack),
  .line_out (line_out),
  .busy     (busy)
);

// File: tb/sim_prio_line_mux.sv
`timescale 1ns/1ps
module sim_prio_line_mux;
  localparam int NUM_DEV = 4;
  localparam int DATA_W  = 8;
  localparam int NVEC    = 12;

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic [NUM_DEV-1:0]        req = '0;
  logic [NUM_DEV*DATA_W-1:0] dev_data;
  logic [NUM_DEV-1:0]        ack_r, ack_c;
  logic [DATA_W-1:0]         line_r, line_c;
  logic                      busy_r, busy_c;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  prio_line_mux #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .req(req), .dev_data(dev_data),
    .ack(ack_r), .line_out(line_r), .busy(busy_r));

  prio_line_mux #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst(rst), .req(req), .dev_data(dev_data),
    .ack(ack_c), .line_out(line_c), .busy(busy_c));

  // {req, expected ack, expected line} with words A=A1 B=B2 C=C3 D=D4
  localparam logic [15:0] VEC [NVEC] = '{
    {4'b0000, 4'b0000, 8'h00}, {4'b0001, 4'b0001, 8'hA1},
    {4'b0010, 4'b0010, 8'hB2}, {4'b0100, 4'b0100, 8'hC3},
    {4'b1000, 4'b1000, 8'hD4}, {4'b1111, 4'b0001, 8'hA1},
    {4'b1110, 4'b0010, 8'hB2}, {4'b1100, 4'b0100, 8'hC3},
    {4'b1010, 4'b0010, 8'hB2}, {4'b0101, 4'b0001, 8'hA1},
    {4'b1001, 4'b0001, 8'hA1}, {4'b0110, 4'b0010, 8'hB2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    dev_data = {8'hD4, 8'hC3, 8'hB2, 8'hA1};
    req = 4'b1111;
    // R7: reset held with requests active keeps the registered copy clear
    repeat (2) @(negedge clk);
    chk("R7 reset ack",  32'(ack_r),  32'h0);
    chk("R7 reset line", 32'(line_r), 32'h0);
    chk("R7 reset busy", 32'(busy_r), 32'h0);
    rst = 1'b0;

    // Vector table: combinational copy same cycle, registered copy after one edge
    for (int v = 0; v < NVEC; v++) begin
      req = VEC[v][15:12];
      #1;
      chk($sformatf("R1 R3 comb ack v%0d", v), 32'(ack_c), 32'(VEC[v][11:8]));
      chk($sformatf("R2 R4 comb line v%0d", v), 32'(line_c), 32'(VEC[v][7:0]));
      chk($sformatf("R5 comb busy v%0d", v), 32'(busy_c), 32'(VEC[v][15:12] != 4'b0));
      @(negedge clk);
      chk($sformatf("R6 reg ack v%0d", v), 32'(ack_r), 32'(VEC[v][11:8]));
      chk($sformatf("R6 reg line v%0d", v), 32'(line_r), 32'(VEC[v][7:0]));
      chk($sformatf("R6 reg busy v%0d", v), 32'(busy_r), 32'(VEC[v][15:12] != 4'b0));
    end

    // R6: before the edge the registered copy still shows the old result
    req = 4'b1000;
    #1;
    chk("R6 reg holds before edge", 32'(line_r), 32'hB2);
    chk("R6 comb follows now",      32'(line_c), 32'hD4);
    @(negedge clk);
    chk("R6 reg after edge", 32'(line_r), 32'hD4);

    // R8: device B wins; words of A, C and D change without effect
    req = 4'b1110;
    @(negedge clk);
    dev_data = {8'h11, 8'h22, 8'hB2, 8'h33};
    #1;
    chk("R8 comb losers ignored", 32'(line_c), 32'hB2);
    @(negedge clk);
    chk("R8 reg losers ignored", 32'(line_r), 32'hB2);
    // R2: the winner's own word is followed
    dev_data = {8'h11, 8'h22, 8'h5A, 8'h33};
    #1;
    chk("R2 comb winner word", 32'(line_c), 32'h5A);
    @(negedge clk);
    chk("R2 reg winner word", 32'(line_r), 32'h5A);
    chk("R3 reg ack B", 32'(ack_r), 32'b0010);

    // R7: reset mid-run with requests active
    rst = 1'b1;
    @(negedge clk);
    chk("R7 midrun ack",  32'(ack_r),  32'h0);
    chk("R7 midrun line", 32'(line_r), 32'h0);
    chk("R7 midrun busy", 32'(busy_r), 32'h0);
    chk("R7 comb unaffected", 32'(ack_c), 32'b0010);
    rst = 1'b0;
    req = 4'b0000;
    @(negedge clk);
    chk("R4 reg idle line", 32'(line_r), 32'h0);
    chk("R5 reg idle busy", 32'(busy_r), 32'h0);

    finish_run();
  end
endmodule